// File: doc/BRIEF.md
# Shared Bus Requester With Lock

This block sits on one of several processor boards that share a common bus to a remote memory. When the local address decoder signals that the processor wants the shared bus, the block raises a request toward a central arbiter. It waits for the arbiter's grant and then takes ownership by driving an ownership line. It gives the bus back after the processor's last access ends. Every handshake line is active-low.

Software can keep ownership across a run of transfers. It writes to the status register with data bit 15 set, which arms a lock. It writes again with bit 15 clear, which disarms it. While the lock is armed, address strobes do not release the bus. With the lock clear, the next address strobe starts the release, and ownership ends when that strobe goes inactive.

Every input passes through a two-stage synchroniser before it reaches the control. The control is a four-state machine:
- IDLE: no request and no ownership.
- REQUEST: the request line is driven to the arbiter.
- OWN: the bus is owned and the lock is honoured.
- RELEASE: the last access strobe is in progress and ownership is still held.

The transitions are:
- IDLE→REQUEST: the access request is seen.
- REQUEST→OWN: the grant is seen.
- OWN→RELEASE: the strobe is active while the lock is clear.
- RELEASE→IDLE: the strobe is inactive again.

Top module: `bus_acquirer`

## Requirements
- R1: A synchronous active-high `rst` returns the machine to IDLE, clears the lock, and drives `arb_req_n` and `bus_own_n` high.
- R2: Every input passes through two synchroniser flops. A change on an input pin therefore affects the outputs at the third rising clock edge after it is applied.
- R3: In IDLE, an active (low) `acc_req_n` moves the machine to REQUEST, where `arb_req_n` is low.
- R4: In REQUEST, an active (low) `arb_grant_n` moves the machine to OWN. On that same edge `bus_own_n` goes low and `arb_req_n` returns high.
- R5: A grant that arrives while no request is pending (IDLE) is ignored, and `bus_own_n` stays high.
- R6: A clock with `stat_sel_n` low and `lock_din` (data bit 15) high arms the lock. While the lock is armed, strobes on `addr_strb_n` in OWN do not release the bus.
- R7: A clock with `stat_sel_n` low and `lock_din` low clears the lock. The next strobe then starts the release.
- R8: In OWN with the lock clear, a low `addr_strb_n` moves the machine to RELEASE. `bus_own_n` stays low until the strobe returns high (its rising edge), and then goes high as the machine returns to IDLE.
- R9: After a release, an access request that is still active starts a new request on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_req_n | input | 1 | Local shared-bus access request from the address decoder, active low |
| arb_grant_n | input | 1 | Grant from the central arbiter, active low |
| addr_strb_n | input | 1 | Processor address strobe, active low |
| stat_sel_n | input | 1 | Status-register select strobe, active low |
| lock_din | input | 1 | Data bit 15 sampled with the status select; 1 arms the lock, 0 clears it |
| arb_req_n | output | 1 | Bus request to the arbiter, active low |
| bus_own_n | output | 1 | Bus busy / ownership indication, active low |

## Verification
The acquire path is tried with the access request held low through a full release. This separates the synchroniser latency, the request-to-grant handover and the immediate re-request. A stray grant while idle shows whether the grant is qualified by a pending request. Strobe pulses are applied once with the lock armed and once after it is cleared. This tells a lock that truly holds ownership apart from one that is ignored or never released. A model in the bench, fed only by the pins, is compared with both outputs on every clock.

// File: rtl/bus_acq_pkg.sv
package bus_acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQUEST = 2'd1,
        ST_OWN     = 2'd2,
        ST_RELEASE = 2'd3
    } acq_state_e;

    // synchronised input vector layout
    localparam int IDX_ACC   = 0;
    localparam int IDX_GNT   = 1;
    localparam int IDX_STRB  = 2;
    localparam int IDX_SEL   = 3;
    localparam int IDX_LOCK  = 4;
    localparam int IN_W      = 5;

    // idle level of each input: active-low lines high, lock data low
    localparam logic [IN_W-1:0] IN_IDLE = 5'b01111;

endpackage

// File: rtl/bus_acq_sync.sv
module bus_acq_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/bus_acq_lock.sv
module bus_acq_lock (
    input  logic clk,
    input  logic rst,
    input  logic sel_act,
    input  logic lock_bit,
    output logic lock_q
);

    // status select samples the lock bit; otherwise the lock is held
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (sel_act) begin
            lock_q <= lock_bit;
        end
    end

endmodule

// File: rtl/bus_acq_fsm.sv
module bus_acq_fsm
    import bus_acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_act,
    input  logic       grant_act,
    input  logic       strb_act,
    input  logic       lock_q,
    output acq_state_e state_q,
    output logic       arb_req_n,
    output logic       bus_own_n
);

    acq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (acc_act)               state_d = ST_REQUEST;
            ST_REQUEST: if (grant_act)             state_d = ST_OWN;
            ST_OWN:     if (strb_act && !lock_q)   state_d = ST_RELEASE;
            ST_RELEASE: if (!strb_act)             state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        arb_req_n = 1'b1;
        bus_own_n = 1'b1;
        unique case (state_q)
            ST_IDLE:    ;
            ST_REQUEST: arb_req_n = 1'b0;
            ST_OWN:     bus_own_n = 1'b0;
            ST_RELEASE: bus_own_n = 1'b0;
            default:    ;
        endcase
    end

endmodule

// File: rtl/bus_acquirer.sv
module bus_acquirer
    import bus_acq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_req_n,
    input  logic arb_grant_n,
    input  logic addr_strb_n,
    input  logic stat_sel_n,
    input  logic lock_din,
    output logic arb_req_n,
    output logic bus_own_n
);

    logic [IN_W-1:0] pins;
    logic [IN_W-1:0] pins_s;
    logic            lock_q;
    logic            strb_s;
    acq_state_e      state_q;

    always_comb begin
        pins           = '0;
        pins[IDX_ACC]  = acc_req_n;
        pins[IDX_GNT]  = arb_grant_n;
        pins[IDX_STRB] = addr_strb_n;
        pins[IDX_SEL]  = stat_sel_n;
        pins[IDX_LOCK] = lock_din;
    end

    bus_acq_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pins),
        .q  (pins_s)
    );

    assign strb_s = pins_s[IDX_STRB];

    bus_acq_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .sel_act (!pins_s[IDX_SEL]),
        .lock_bit(pins_s[IDX_LOCK]),
        .lock_q  (lock_q)
    );

    bus_acq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .acc_act  (!pins_s[IDX_ACC]),
        .grant_act(!pins_s[IDX_GNT]),
        .strb_act (!strb_s),
        .lock_q   (lock_q),
        .state_q  (state_q),
        .arb_req_n(arb_req_n),
        .bus_own_n(bus_own_n)
    );

endmodule

// File: rtl/bus_acquirer_chk.sv
module bus_acquirer_chk
    import bus_acq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       arb_req_n,
    input logic       bus_own_n,
    input acq_state_e state_q,
    input logic       lock_q,
    input logic       strb_s
);

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (arb_req_n && bus_own_n));

    // R4
    own_handover_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_own_n) |-> $rose(arb_req_n));

    // R5
    idle_no_own_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> bus_own_n);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OWN && lock_q) |=> !bus_own_n);

    // R8
    release_on_strobe_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_own_n) |-> ($past(strb_s) && $past(state_q == ST_RELEASE)));

endmodule

bind bus_acquirer bus_acquirer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .arb_req_n(arb_req_n),
    .bus_own_n(bus_own_n),
    .state_q  (state_q),
    .lock_q   (lock_q),
    .strb_s   (strb_s)
);

// File: tb/test_bus_acquirer.sv
`timescale 1ns/1ps
module test_bus_acquirer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_req_n = 1'b1;
    logic arb_grant_n = 1'b1;
    logic addr_strb_n = 1'b1;
    logic stat_sel_n = 1'b1;
    logic lock_din = 1'b0;
    logic arb_req_n;
    logic bus_own_n;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    bus_acquirer i_bus_acquirer (
        .clk        (clk),
        .rst        (rst),
        .acc_req_n  (acc_req_n),
        .arb_grant_n(arb_grant_n),
        .addr_strb_n(addr_strb_n),
        .stat_sel_n (stat_sel_n),
        .lock_din   (lock_din),
        .arb_req_n  (arb_req_n),
        .bus_own_n  (bus_own_n)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // behavioural model: 0 idle, 1 requesting, 2 owning, 3 releasing
    int  m_st = 0;
    bit  m_lock = 0;
    bit  m_valid = 0;
    bit [4:0] m_q[$];   // {lock, sel, strb, gnt, acc}

    always @(posedge clk) begin
        if (rst) begin
            m_q = {5'b01111, 5'b01111};
            m_st = 0;
            m_lock = 0;
        end else begin
            bit [4:0] s;
            s = m_q.pop_front();
            m_q.push_back({lock_din, stat_sel_n, addr_strb_n, arb_grant_n, acc_req_n});
            case (m_st)
                0: if (!s[0]) m_st = 1;
                1: if (!s[1]) m_st = 2;
                2: if (!s[2] && !m_lock) m_st = 3;
                3: if (s[2]) m_st = 0;
                default: m_st = 0;
            endcase
            if (!s[3]) m_lock = s[4];
        end
        if (rst) m_q = {5'b01111, 5'b01111};
        m_valid = 1;
    end

    always @(negedge clk) begin
        cycles++;
        if (m_valid) begin
            chk(cur_tag, "model arb_req_n", arb_req_n, (m_st == 1) ? 1'b0 : 1'b1);
            chk(cur_tag, "model bus_own_n", bus_own_n, (m_st >= 2) ? 1'b0 : 1'b1);
        end
        if (cycles > 20000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_lock(bit v);
        stat_sel_n = 1'b0;
        lock_din = v;
        step(1);
        stat_sel_n = 1'b1;
        lock_din = 1'b0;
    endtask

    initial begin
        step(5);
        cur_tag = "R1";
        chk("R1", "reset arb_req_n", arb_req_n, 1'b1);
        chk("R1", "reset bus_own_n", bus_own_n, 1'b1);
        rst = 1'b0;
        step(3);

        // R2 / R3: request latency of three edges
        cur_tag = "R2";
        acc_req_n = 1'b0;
        step(2);
        chk("R2", "request not yet after two edges", arb_req_n, 1'b1);
        step(1);
        chk("R3", "request active after third edge", arb_req_n, 1'b0);
        chk("R3", "no ownership while requesting", bus_own_n, 1'b1);
        step(4);
        chk("R3", "request held without grant", arb_req_n, 1'b0);

        // R4: grant handover
        cur_tag = "R4";
        arb_grant_n = 1'b0;
        step(2);
        chk("R4", "still requesting before sync", arb_req_n, 1'b0);
        step(1);
        chk("R4", "ownership taken", bus_own_n, 1'b0);
        chk("R4", "request withdrawn same edge", arb_req_n, 1'b1);
        arb_grant_n = 1'b1;
        step(4);

        // R8: unlocked strobe release, R9: re-request
        cur_tag = "R8";
        addr_strb_n = 1'b0;
        step(3);
        chk("R8", "held during last strobe", bus_own_n, 1'b0);
        step(3);
        chk("R8", "held while strobe low", bus_own_n, 1'b0);
        addr_strb_n = 1'b1;
        step(2);
        chk("R8", "held until strobe end synced", bus_own_n, 1'b0);
        step(1);
        chk("R8", "released after strobe end", bus_own_n, 1'b1);
        cur_tag = "R9";
        chk("R9", "no request on release edge", arb_req_n, 1'b1);
        step(1);
        chk("R9", "re-request next edge", arb_req_n, 1'b0);
        acc_req_n = 1'b1;
        step(4);
        chk("R9", "request stays after access drops", arb_req_n, 1'b0);
        arb_grant_n = 1'b0;
        step(4);
        arb_grant_n = 1'b1;
        addr_strb_n = 1'b0;
        step(2);
        addr_strb_n = 1'b1;
        step(6);
        chk("R8", "released after short strobe", bus_own_n, 1'b1);

        // R5: stray grant in idle
        cur_tag = "R5";
        arb_grant_n = 1'b0;
        step(6);
        chk("R5", "stray grant ignored", bus_own_n, 1'b1);
        chk("R5", "no request from stray grant", arb_req_n, 1'b1);
        arb_grant_n = 1'b1;
        step(4);

        // R6: lock holds ownership across strobes
        cur_tag = "R6";
        acc_req_n = 1'b0;
        step(4);
        arb_grant_n = 1'b0;
        step(4);
        arb_grant_n = 1'b1;
        acc_req_n = 1'b1;
        write_lock(1'b1);
        step(3);
        for (int k = 0; k < 3; k++) begin
            addr_strb_n = 1'b0;
            step(3);
            addr_strb_n = 1'b1;
            step(4);
            chk("R6", "locked ownership kept", bus_own_n, 1'b0);
        end

        // R7: clear lock, next strobe releases
        cur_tag = "R7";
        write_lock(1'b0);
        step(4);
        chk("R7", "still owned after unlock", bus_own_n, 1'b0);
        addr_strb_n = 1'b0;
        step(4);
        addr_strb_n = 1'b1;
        step(4);
        chk("R7", "released after unlocked strobe", bus_own_n, 1'b1);

        // R6: lock armed before acquisition persists
        cur_tag = "R6";
        write_lock(1'b1);
        acc_req_n = 1'b0;
        step(4);
        arb_grant_n = 1'b0;
        step(4);
        arb_grant_n = 1'b1;
        acc_req_n = 1'b1;
        addr_strb_n = 1'b0;
        step(4);
        addr_strb_n = 1'b1;
        step(4);
        chk("R6", "pre-armed lock holds", bus_own_n, 1'b0);
        write_lock(1'b0);
        addr_strb_n = 1'b0;
        step(4);
        addr_strb_n = 1'b1;
        step(4);
        chk("R7", "final release", bus_own_n, 1'b1);

        // R1: reset mid-ownership
        cur_tag = "R1";
        acc_req_n = 1'b0;
        step(4);
        arb_grant_n = 1'b0;
        step(4);
        rst = 1'b1;
        acc_req_n = 1'b1;
        arb_grant_n = 1'b1;
        step(2);
        chk("R1", "reset drops ownership", bus_own_n, 1'b1);
        chk("R1", "reset drops request", arb_req_n, 1'b1);
        rst = 1'b0;
        step(4);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule